// File: doc/BRIEF.md
# Multi-plane flash address sequencer

This block turns one flash command into the ordered list of (block, page) addresses that a flash back end issues one operation at a time. A command carries an operation (read, program, copyback or erase), a start block, a start page and a page count. The plane count, the multi-plane enables and the cache enables are sampled at the moment the command is accepted. The block validates the command in the cycle after acceptance. A good command is then walked out as a stream of address steps. A bad command raises a one-cycle error pulse and produces no step.

In multi-plane mode the plane index moves fastest: consecutive steps go to blocks start, start+1, ... start+P-1, then back to the start block with the page one higher. In single-plane mode the block stays put and the page rises on every step. Erase issues one step per plane back to back (one step when single-plane), always at the start page.

The command port and the step port are valid/ready. `cmd_ready` is high only while the block is idle, so a command offered during a run is not taken. On the step port `step_valid`, once high, stays high with a stable address until `step_ready` is sampled high. The consumer may stall for any number of cycles, and no step is skipped or repeated.

Top module: `mp_addr_seq`

## Requirements
- R1: After reset `cmd_ready` is 1, and `step_valid`, `done`, `desc_err` and `cmd_err` are 0.
- R2: For read, program and copyback with multi-plane active and plane count P, step i (from 0) has block = start block + (i mod P) and page = start page + floor(i / P), and the command emits exactly page-count steps.
- R3: Multi-plane is active for read when `cfg_mp_rd_en` is 1, and for program, copyback and erase when `cfg_mp_wr_en` is 1. When it is inactive, step i has block = start block and page = start page + i. A zero page count is rejected, and the plane count and block alignment are not checked.
- R4: With multi-plane active, a non-erase command whose page count is zero or not a multiple of P is rejected.
- R5: With multi-plane active, a command whose start block is not in plane 0 (start block mod P is not 0) is rejected, erase included.
- R6: With multi-plane active, a plane count of 0 is rejected.
- R7: A rejection shows as a one-cycle pulse two clock edges after the accepting edge. It is `desc_err` when `cmd_pio` was 0, and `cmd_err` together with `err_thread` = the accepted `cmd_thread` when `cmd_pio` was 1. No step is emitted.
- R8: Erase ignores the page count. It emits P steps at blocks start..start+P-1 when multi-plane is active, or 1 step at the start block otherwise. Every erase step carries the start page.
- R9: `step_cached` is 1 on every step of a non-erase command when multi-plane is active, the cache enable for its direction is set (`cfg_cache_rd_en` for read, `cfg_cache_wr_en` for program and copyback), and page count > P. Otherwise it is 0.
- R10: The first step is valid two edges after the accepting edge. A step not taken holds its address. `step_last` marks the final step. `done` pulses for one cycle right after the final step is taken.
- R11: Commands are taken only while idle. A command presented while busy, together with any change to the command fields or configuration, does not alter the running sequence.
- R12: Operation encoding on `cmd_op`: 0 read, 1 program, 2 copyback, 3 erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_planes | input | PLN_W | Plane count P, sampled at acceptance |
| cfg_mp_rd_en | input | 1 | Multi-plane enable for read |
| cfg_mp_wr_en | input | 1 | Multi-plane enable for program, copyback, erase |
| cfg_cache_rd_en | input | 1 | Cache enable for read |
| cfg_cache_wr_en | input | 1 | Cache enable for program and copyback |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_op | input | 2 | Operation code (R12) |
| cmd_block | input | BLK_W | Start block |
| cmd_page | input | PAGE_W | Start page |
| cmd_count | input | CNT_W | Page count |
| cmd_pio | input | 1 | 1 = direct command mode, 0 = descriptor mode |
| cmd_thread | input | THR_W | Thread of a direct command |
| step_valid | output | 1 | Address step offered |
| step_ready | input | 1 | Consumer takes the step |
| step_block | output | BLK_W | Block of this step |
| step_page | output | PAGE_W | Page of this step |
| step_last | output | 1 | Final step of the command |
| step_cached | output | 1 | Cached multi-plane sequence |
| done | output | 1 | One-cycle pulse after the final step |
| desc_err | output | 1 | Descriptor-mode reject pulse |
| cmd_err | output | 1 | Direct-mode reject pulse |
| err_thread | output | THR_W | Thread of the rejected direct command |

## Verification
The hardest situation to reach is a multi-step walk that wraps the plane index while the consumer stalls on the exact step where the page advances. The command port is also still being driven with altered fields and a new configuration at that point. The bench sweeps every plane count up to 4 (0 included), every operation, many page counts, aligned and misaligned start blocks, and all enable combinations. A stall pattern is derived from a running cycle count, so stalls land on different step indices from one command to the next. The command lines are kept asserted with junk values during each run.

// File: rtl/mp_seq_pkg.sv
package mp_seq_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_COPY  = 2'd2,
    OP_ERASE = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_RUN   = 2'd2
  } state_e;

endpackage

// File: rtl/mp_cmd_check.sv
module mp_cmd_check
  import mp_seq_pkg::*;
#(
  parameter int BLK_W = 12,
  parameter int CNT_W = 9,
  parameter int PLN_W = 3
) (
  input  op_e              op,
  input  logic [PLN_W-1:0] planes,
  input  logic             mp_rd_en,
  input  logic             mp_wr_en,
  input  logic             cache_rd_en,
  input  logic             cache_wr_en,
  input  logic [BLK_W-1:0] blk,
  input  logic [CNT_W-1:0] cnt,
  output logic             ok,
  output logic [PLN_W-1:0] lim,
  output logic [CNT_W-1:0] total,
  output logic             cached
);

  logic             is_read;
  logic             is_erase;
  logic             multi;
  logic             pl_zero;
  logic [BLK_W-1:0] blk_rem;
  logic [CNT_W-1:0] cnt_rem;
  logic [BLK_W-1:0] planes_b;
  logic [CNT_W-1:0] planes_c;

  assign is_read  = (op == OP_READ);
  assign is_erase = (op == OP_ERASE);
  assign multi    = is_read ? mp_rd_en : mp_wr_en;
  assign pl_zero  = (planes == '0);
  assign planes_b = BLK_W'(planes);
  assign planes_c = CNT_W'(planes);

  // remainder logic, guarded against a zero divisor
  always_comb begin
    blk_rem = '0;
    cnt_rem = '0;
    if (!pl_zero) begin
      blk_rem = blk % planes_b;
      cnt_rem = cnt % planes_c;
    end
  end

  always_comb begin
    ok     = 1'b1;
    lim    = PLN_W'(1);
    total  = cnt;
    cached = 1'b0;
    if (multi) begin
      lim = planes;
      if (pl_zero || blk_rem != '0) ok = 1'b0;
      if (is_erase) begin
        total = planes_c;
      end else begin
        if (cnt == '0 || cnt_rem != '0) ok = 1'b0;
        cached = (is_read ? cache_rd_en : cache_wr_en) && (cnt > planes_c);
      end
    end else begin
      if (is_erase) total = CNT_W'(1);
      else if (cnt == '0) ok = 1'b0;
    end
  end

endmodule

// File: rtl/mp_step_gen.sv
module mp_step_gen #(
  parameter int BLK_W  = 12,
  parameter int PAGE_W = 8,
  parameter int CNT_W  = 9,
  parameter int PLN_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  logic              hold_page,
  input  logic [BLK_W-1:0]  start_blk,
  input  logic [PAGE_W-1:0] start_pg,
  input  logic [PLN_W-1:0]  lim,
  input  logic [CNT_W-1:0]  total,
  output logic [BLK_W-1:0]  blk,
  output logic [PAGE_W-1:0] pg,
  output logic              last
);

  logic [PLN_W-1:0]  plane_idx;
  logic [PAGE_W-1:0] page_off;
  logic [CNT_W-1:0]  left;
  logic              sweep_end;

  assign sweep_end = (plane_idx == lim - PLN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plane_idx <= '0;
      page_off  <= '0;
      left      <= '0;
    end else if (load) begin
      plane_idx <= '0;
      page_off  <= '0;
      left      <= total;
    end else if (adv) begin
      left <= left - CNT_W'(1);
      if (sweep_end) begin
        plane_idx <= '0;
        if (!hold_page) page_off <= page_off + PAGE_W'(1);
      end else begin
        plane_idx <= plane_idx + PLN_W'(1);
      end
    end
  end

  assign blk  = start_blk + BLK_W'(plane_idx);
  assign pg   = start_pg + page_off;
  assign last = (left == CNT_W'(1));

  // R2: the plane index never leaves the configured sweep while steps remain
  a_r2_plane_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (left != '0) |-> (plane_idx < lim));

  // R10: a step is only taken while steps remain
  a_r10_no_underrun: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (left != '0));

endmodule

// File: rtl/mp_addr_seq.sv
module mp_addr_seq
  import mp_seq_pkg::*;
#(
  parameter int BLK_W   = 12,
  parameter int PAGE_W  = 8,
  parameter int CNT_W   = 9,
  parameter int PLN_W   = 3,
  parameter int THREADS = 4,
  localparam int THR_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PLN_W-1:0]  cfg_planes,
  input  logic              cfg_mp_rd_en,
  input  logic              cfg_mp_wr_en,
  input  logic              cfg_cache_rd_en,
  input  logic              cfg_cache_wr_en,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [BLK_W-1:0]  cmd_block,
  input  logic [PAGE_W-1:0] cmd_page,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic              cmd_pio,
  input  logic [THR_W-1:0]  cmd_thread,
  output logic              step_valid,
  input  logic              step_ready,
  output logic [BLK_W-1:0]  step_block,
  output logic [PAGE_W-1:0] step_page,
  output logic              step_last,
  output logic              step_cached,
  output logic              done,
  output logic              desc_err,
  output logic              cmd_err,
  output logic [THR_W-1:0]  err_thread
);

  state_e            state;
  op_e               op_q;
  logic [BLK_W-1:0]  blk_q;
  logic [PAGE_W-1:0] pg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [PLN_W-1:0]  planes_q;
  logic              mrd_q, mwr_q, crd_q, cwr_q, pio_q;
  logic [THR_W-1:0]  thr_q;
  logic              cached_q;

  logic              accept;
  logic              chk_ok;
  logic [PLN_W-1:0]  chk_lim;
  logic [CNT_W-1:0]  chk_total;
  logic              chk_cached;
  logic              load;
  logic              adv;

  assign cmd_ready = (state == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign step_valid = (state == ST_RUN);
  assign adv       = step_valid && step_ready;
  assign load      = (state == ST_CHECK) && chk_ok;

  // command and configuration capture at acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q     <= OP_READ;
      blk_q    <= '0;
      pg_q     <= '0;
      cnt_q    <= '0;
      planes_q <= '0;
      mrd_q    <= 1'b0;
      mwr_q    <= 1'b0;
      crd_q    <= 1'b0;
      cwr_q    <= 1'b0;
      pio_q    <= 1'b0;
      thr_q    <= '0;
    end else if (accept) begin
      op_q     <= op_e'(cmd_op);
      blk_q    <= cmd_block;
      pg_q     <= cmd_page;
      cnt_q    <= cmd_count;
      planes_q <= cfg_planes;
      mrd_q    <= cfg_mp_rd_en;
      mwr_q    <= cfg_mp_wr_en;
      crd_q    <= cfg_cache_rd_en;
      cwr_q    <= cfg_cache_wr_en;
      pio_q    <= cmd_pio;
      thr_q    <= cmd_thread;
    end
  end

  mp_cmd_check #(
    .BLK_W(BLK_W), .CNT_W(CNT_W), .PLN_W(PLN_W)
  ) u_check (
    .op          (op_q),
    .planes      (planes_q),
    .mp_rd_en    (mrd_q),
    .mp_wr_en    (mwr_q),
    .cache_rd_en (crd_q),
    .cache_wr_en (cwr_q),
    .blk         (blk_q),
    .cnt         (cnt_q),
    .ok          (chk_ok),
    .lim         (chk_lim),
    .total       (chk_total),
    .cached      (chk_cached)
  );

  mp_step_gen #(
    .BLK_W(BLK_W), .PAGE_W(PAGE_W), .CNT_W(CNT_W), .PLN_W(PLN_W)
  ) u_steps (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .adv       (adv),
    .hold_page (op_q == OP_ERASE),
    .start_blk (blk_q),
    .start_pg  (pg_q),
    .lim       (chk_lim),
    .total     (chk_total),
    .blk       (step_block),
    .pg        (step_page),
    .last      (step_last)
  );

  // sequencing control and one-cycle status pulses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      done       <= 1'b0;
      desc_err   <= 1'b0;
      cmd_err    <= 1'b0;
      err_thread <= '0;
      cached_q   <= 1'b0;
    end else begin
      done     <= 1'b0;
      desc_err <= 1'b0;
      cmd_err  <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) state <= ST_CHECK;
        ST_CHECK: begin
          if (chk_ok) begin
            state    <= ST_RUN;
            cached_q <= chk_cached;
          end else begin
            state <= ST_IDLE;
            if (pio_q) begin
              cmd_err    <= 1'b1;
              err_thread <= thr_q;
            end else begin
              desc_err <= 1'b1;
            end
          end
        end
        ST_RUN: if (adv && step_last) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign step_cached = cached_q;

  // R7: a reject never coincides with a step offer
  a_r7_no_step_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_err || cmd_err) |-> !step_valid);

  // R7: at most one status pulse at a time
  a_r7_single_status: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({desc_err, cmd_err, done}));

  // R10: a stalled step keeps its address
  a_r10_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && !step_ready) |=>
      (step_valid && $stable(step_block) && $stable(step_page) && $stable(step_last)));

  // R10: done follows the final step
  a_r10_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && step_last) |=> (done && !step_valid));

  // R11: an accepted command is validated before any step
  a_r11_check_first: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!step_valid && !cmd_ready));

endmodule

// File: tb/mp_addr_seq_test.sv
module mp_addr_seq_test;

  localparam int BLK_W = 8, PAGE_W = 6, CNT_W = 5, PLN_W = 3, THREADS = 4, THR_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PLN_W-1:0] cfg_planes = '0;
  logic cfg_mp_rd_en = 0, cfg_mp_wr_en = 0, cfg_cache_rd_en = 0, cfg_cache_wr_en = 0;
  logic cmd_valid = 0;
  logic cmd_ready;
  logic [1:0] cmd_op = '0;
  logic [BLK_W-1:0] cmd_block = '0;
  logic [PAGE_W-1:0] cmd_page = '0;
  logic [CNT_W-1:0] cmd_count = '0;
  logic cmd_pio = 0;
  logic [THR_W-1:0] cmd_thread = '0;
  logic step_valid, step_ready = 0;
  logic [BLK_W-1:0] step_block;
  logic [PAGE_W-1:0] step_page;
  logic step_last, step_cached, done, desc_err, cmd_err;
  logic [THR_W-1:0] err_thread;

  int vectors = 0;
  int miscompares = 0;
  int gcyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) gcyc <= gcyc + 1;

  mp_addr_seq #(.BLK_W(BLK_W), .PAGE_W(PAGE_W), .CNT_W(CNT_W), .PLN_W(PLN_W),
                .THREADS(THREADS)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_planes(cfg_planes),
    .cfg_mp_rd_en(cfg_mp_rd_en), .cfg_mp_wr_en(cfg_mp_wr_en),
    .cfg_cache_rd_en(cfg_cache_rd_en), .cfg_cache_wr_en(cfg_cache_wr_en),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_block(cmd_block), .cmd_page(cmd_page), .cmd_count(cmd_count),
    .cmd_pio(cmd_pio), .cmd_thread(cmd_thread), .step_valid(step_valid),
    .step_ready(step_ready), .step_block(step_block), .step_page(step_page),
    .step_last(step_last), .step_cached(step_cached), .done(done),
    .desc_err(desc_err), .cmd_err(cmd_err), .err_thread(err_thread));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin : watchdog
    #(5.0 * 190000);
    miscompares++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  task automatic run_cmd(input int op, input int pl, input int mrd, input int mwr,
                         input int crd, input int cwr, input int blk, input int pg,
                         input int cnt, input int pio, input int thr);
    bit multi, rej, erase, cach, held;
    int nsteps, lim, idx, stalls, hb, hp, guard;
    erase = (op == 3);
    multi = (op == 0) ? mrd[0] : mwr[0];
    if (erase) rej = multi && (pl == 0 || (blk % pl) != 0);
    else if (multi) rej = (pl == 0) || (cnt == 0) || (cnt % pl) != 0 || (blk % pl) != 0;
    else rej = (cnt == 0);
    lim = multi ? pl : 1;
    nsteps = erase ? lim : cnt;
    cach = !erase && multi && (((op == 0) ? crd : cwr) != 0) && (cnt > pl);

    @(negedge clk);
    check(cmd_ready == 1'b1, "R11 idle ready", int'(cmd_ready), 1);
    cmd_op = 2'(op); cfg_planes = PLN_W'(pl);
    cfg_mp_rd_en = mrd[0]; cfg_mp_wr_en = mwr[0];
    cfg_cache_rd_en = crd[0]; cfg_cache_wr_en = cwr[0];
    cmd_block = BLK_W'(blk); cmd_page = PAGE_W'(pg); cmd_count = CNT_W'(cnt);
    cmd_pio = pio[0]; cmd_thread = THR_W'(thr); cmd_valid = 1'b1;
    step_ready = 1'b0;

    @(negedge clk);  // validation cycle; scramble inputs while busy (R11)
    check(!step_valid && !desc_err && !cmd_err, "R10 no output during check",
          int'(step_valid), 0);
    check(cmd_ready == 1'b0, "R11 busy not ready", int'(cmd_ready), 0);
    cmd_op = ~cmd_op; cmd_block = cmd_block + 8'd3; cmd_count = cmd_count + 5'd1;
    cfg_planes = cfg_planes + 3'd1; cfg_mp_rd_en = ~cfg_mp_rd_en;
    cfg_mp_wr_en = ~cfg_mp_wr_en; cmd_pio = ~cmd_pio; cmd_thread = ~cmd_thread;

    @(negedge clk);
    if (rej) begin
      cmd_valid = 1'b0;
      check(!step_valid, "R7 no step on reject", int'(step_valid), 0);
      if (pio != 0) begin
        check(cmd_err && !desc_err, "R7 direct error", int'({cmd_err, desc_err}), 2);
        check(int'(err_thread) == thr, "R7 thread", int'(err_thread), thr);
      end else begin
        check(desc_err && !cmd_err, "R7 descriptor error", int'({cmd_err, desc_err}), 1);
      end
      @(negedge clk);
      check(!desc_err && !cmd_err && !step_valid && cmd_ready,
            "R4 R5 R6 reject ends idle", int'({desc_err, cmd_err, step_valid, cmd_ready}), 1);
      return;
    end

    check(step_valid == 1'b1 && !desc_err && !cmd_err, "R10 first step timing",
          int'(step_valid), 1);
    idx = 0; stalls = 0; held = 0; hb = 0; hp = 0; guard = 0;
    while (idx < nsteps && guard < 400) begin
      guard++;
      if (idx > 0 || held) begin
        if (!step_valid) begin
          check(1'b0, "R10 step valid held", int'(step_valid), 1);
          break;
        end
      end
      if (held) begin
        check(int'(step_block) == hb && int'(step_page) == hp, "R10 stall hold",
              int'(step_block), hb);
      end
      if (stalls >= 2 || ((gcyc * 5 + idx * 3) % 4) != 0) begin
        step_ready = 1'b1; stalls = 0; held = 0;
        check(int'(step_block) == ((blk + idx % lim) & 8'hff),
              erase ? "R8 erase block" : (multi ? "R2 block" : "R3 block"),
              int'(step_block), blk + idx % lim);
        check(int'(step_page) == (erase ? pg : pg + idx / lim) % 64,
              erase ? "R8 erase page" : (multi ? "R2 page" : "R3 page"),
              int'(step_page), erase ? pg : pg + idx / lim);
        check(step_last == (idx == nsteps - 1), "R10 last flag",
              int'(step_last), int'(idx == nsteps - 1));
        check(step_cached == cach, "R9 cached flag", int'(step_cached), int'(cach));
        idx++;
        if (idx == nsteps) cmd_valid = 1'b0;
      end else begin
        step_ready = 1'b0; stalls++; held = 1;
        hb = int'(step_block); hp = int'(step_page);
      end
      @(negedge clk);
    end
    step_ready = 1'b0;
    check(idx == nsteps, "R2 R8 step count", idx, nsteps);
    check(done && !step_valid && cmd_ready, "R10 done pulse", int'(done), 1);
    @(negedge clk);
    check(!done, "R10 done one cycle", int'(done), 0);
  endtask

  initial begin : main
    int n;
    n = 0;
    #1;
    check(cmd_ready && !step_valid && !done && !desc_err && !cmd_err, "R1 reset state",
          int'({cmd_ready, step_valid, done, desc_err, cmd_err}), 16);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(cmd_ready && !step_valid && !done && !desc_err && !cmd_err, "R1 after reset",
          int'({cmd_ready, step_valid, done, desc_err, cmd_err}), 16);
    for (int pl = 0; pl <= 4; pl++)
      for (int op = 0; op < 4; op++)          // R12 encodings 0..3
        for (int ci = 0; ci < 8; ci++)
          for (int bi = 0; bi < 3; bi++)
            for (int mp = 0; mp < 4; mp++)
              for (int cc = 0; cc < 2; cc++) begin
                int cnts[8] = '{0, 1, 2, 3, 4, 6, 8, 9};
                int blks[3] = '{0, 4, 6};
                n++;
                run_cmd(op, pl, mp & 1, (mp >> 1) & 1, cc, cc, blks[bi], 5,
                        cnts[ci], n & 1, n % THREADS);
              end
    finish_run();
  end

endmodule